// File: doc/BRIEF.md
# CAN Controller Control-Register Front End

This block is the register-facing front end of a CAN controller. It keeps the controller's operating-mode word, turns writes to a write-only command location into one-clock strobes for the protocol engine, and presents a read-only status word built from flags that the engine drives. A plain 32-bit register bus reaches it: a byte address, a write enable, write data and registered read data.

The controller comes out of reset in its initialisation state, with the init bit of the mode word set. Software sets up the controller while that bit is held. It then clears the bit to go on the bus, and polls the bit to confirm the change. The low-power (sleep) selection and the acceptance-filter arrangement are frozen whenever the init bit is clear. Commands are accepted only while the controller is out of initialisation. The block also holds the receive-overrun flag, because a command clears it.

Top module: `can_ctrl_regs`

## Requirements
- R1: After reset the mode word reads 0x0000_0001, `init_mode` is 1, every command strobe is 0, and read data is 0.
- R2: The mode word lives at byte offset 0x00. Its bit 0 is init, bit 1 is listen-only, bit 2 is loopback, bit 3 is single-filter (1) or dual-filter (0), and bit 4 is sleep (1) or awake (0). A read returns the stored five bits with zeros above them.
- R3: A mode write changes bits 3 and 4 only when the stored init bit is 1 at the time of the write. Bits 0 to 2 take the written value on every mode write.
- R4: A write to byte offset 0x04 while init is 0 drives `cmd_strobe` with write-data bits 5:0 for exactly the one cycle after the write, then returns it to 0. Strobe bit 0 requests transmission, bit 1 aborts, bit 2 releases the receive buffer, bit 3 clears overrun, bit 4 requests self-reception and bit 5 requests bus-off.
- R5: A command write made while the stored init bit is 1 produces no strobe.
- R6: A read of offset 0x04 returns zero.
- R7: The status word at offset 0x08 resets to 0x0000_003C. After reset, its bits hold the engine flags sampled at the previous clock: bit 0 receive ready, bit 2 transmit-buffer ready, bit 3 transmission complete, bit 4 receive busy, bit 5 transmit busy, bit 6 error status and bit 7 bus-off. Bit 1 holds the stored overrun flag.
- R8: The overrun flag is set by an `ovr_event` pulse. It is cleared on the cycle after the clear-overrun strobe. When both happen in the same cycle, the set wins.
- R9: When loopback and listen-only are both stored as 1, `loopback_mode` is 1 and `listen_mode` is 0. Otherwise `listen_mode` follows bit 1.
- R10: `bus_rdata` is registered. It shows the addressed word one cycle after the address is presented. Any address other than 0x00, 0x04 and 0x08 reads zero.
- R11: A mode write with bit 0 cleared makes `init_mode` 0 from the next cycle, and a read of the mode word then shows bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write enable for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| init_mode | output | 1 | Controller held in initialisation |
| listen_mode | output | 1 | Listen-only operation, after loopback priority |
| loopback_mode | output | 1 | Internal loopback operation |
| single_filter | output | 1 | Single acceptance filter selected |
| sleep_mode | output | 1 | Low-power state requested |
| cmd_strobe | output | 6 | One-cycle command pulses |
| rx_ready | input | 1 | Engine: receive buffer holds a message |
| tx_ready | input | 1 | Engine: transmit buffer free |
| tx_done | input | 1 | Engine: last transmission completed |
| rx_busy | input | 1 | Engine: receiving |
| tx_busy | input | 1 | Engine: transmitting |
| err_warn | input | 1 | Engine: error counter at warning level |
| bus_off | input | 1 | Engine: node is bus-off |
| ovr_event | input | 1 | Engine: a message was lost to overrun |

## Verification
The embedded properties hold on every cycle. They check that sleep and filter bits stay frozen outside initialisation, and that every strobe comes from a permitted command write carrying the same bits. They also check that overrun is set by an event and cleared after the strobe, that clearing init leaves initialisation, and that the command address reads zero. Only the bench scenarios can show the rest. These are the reset contents, the exact read-back of each word for chosen patterns, the loopback-over-listen resolution, zero data from unmapped addresses, and the ordering of a lock, re-entry into initialisation and a later unlock.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;
  localparam int MODE_W = 5;
  localparam int CMD_W  = 6;
  localparam int STAT_W = 8;

  // mode word bit positions
  localparam int MB_INIT   = 0;
  localparam int MB_LISTEN = 1;
  localparam int MB_LOOP   = 2;
  localparam int MB_FILT   = 3;
  localparam int MB_SLEEP  = 4;

  // command bit positions
  localparam int CB_CLR_OVR = 3;

  // status bit positions
  localparam int SB_RX_RDY  = 0;
  localparam int SB_OVR     = 1;

  localparam logic [MODE_W-1:0] MODE_RESET = 5'h01;
  localparam logic [STAT_W-1:0] STAT_RESET = 8'h3C;

  typedef enum logic [1:0] {
    SEL_MODE,
    SEL_CMD,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/can_mode_reg.sv
module can_mode_reg
  import can_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic              init_o,
  output logic              listen_o,
  output logic              loop_o,
  output logic              filt_o,
  output logic              sleep_o
);
  localparam int LOCK_LO = MB_FILT;
  localparam int LOCK_HI = MB_SLEEP;

  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_mode) begin
      mode_d[LOCK_LO-1:0] = wdata[LOCK_LO-1:0];
      if (mode_q[MB_INIT])
        mode_d[LOCK_HI:LOCK_LO] = wdata[LOCK_HI:LOCK_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RESET;
    else     mode_q <= mode_d;
  end

  assign init_o   = mode_q[MB_INIT];
  assign loop_o   = mode_q[MB_LOOP];
  assign listen_o = mode_q[MB_LISTEN] & ~mode_q[MB_LOOP];
  assign filt_o   = mode_q[MB_FILT];
  assign sleep_o  = mode_q[MB_SLEEP];

  // R3
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_q[MB_INIT]) |-> mode_q[LOCK_HI:LOCK_LO] == $past(mode_q[LOCK_HI:LOCK_LO]));

  // R11
  init_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && !wdata[MB_INIT]) |=> !init_o);
endmodule

// File: rtl/can_cmd_strobe.sv
module can_cmd_strobe
  import can_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cmd,
  input  logic             in_init,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] strobe_q
);
  logic accept;
  assign accept = wr_cmd & ~in_init;

  for (genvar i = 0; i < CMD_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) strobe_q[i] <= 1'b0;
      else     strobe_q[i] <= accept & wdata[i];
    end
  end

  // R5
  cmd_src_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_q != '0) |-> $past(wr_cmd && !in_init));

  // R4
  cmd_copy_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_cmd && !in_init) |-> strobe_q == $past(wdata));
endmodule

// File: rtl/can_status_word.sv
module can_status_word
  import can_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_ready,
  input  logic              tx_ready,
  input  logic              tx_done,
  input  logic              rx_busy,
  input  logic              tx_busy,
  input  logic              err_warn,
  input  logic              bus_off,
  input  logic              ovr_event,
  input  logic              clr_ovr,
  output logic [STAT_W-1:0] status_q
);
  logic ovr_d;

  always_comb begin
    if (ovr_event)    ovr_d = 1'b1;
    else if (clr_ovr) ovr_d = 1'b0;
    else              ovr_d = status_q[SB_OVR];
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= STAT_RESET;
    else     status_q <= {bus_off, err_warn, tx_busy, rx_busy,
                          tx_done, tx_ready, ovr_d, rx_ready};
  end

  // R8
  ovr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr_ovr && !ovr_event) |-> !status_q[SB_OVR]);

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ovr_event) |-> status_q[SB_OVR]);
endmodule

// File: rtl/can_ctrl_regs.sv
module can_ctrl_regs
  import can_ctrl_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] MODE_OFS = 8'h00,
  parameter logic [AW-1:0] CMD_OFS  = 8'h04,
  parameter logic [AW-1:0] STAT_OFS = 8'h08
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          init_mode,
  output logic          listen_mode,
  output logic          loopback_mode,
  output logic          single_filter,
  output logic          sleep_mode,
  output logic [5:0]    cmd_strobe,
  input  logic          rx_ready,
  input  logic          tx_ready,
  input  logic          tx_done,
  input  logic          rx_busy,
  input  logic          tx_busy,
  input  logic          err_warn,
  input  logic          bus_off,
  input  logic          ovr_event
);
  reg_sel_e          sel;
  logic [MODE_W-1:0] mode_q;
  logic [STAT_W-1:0] status_q;
  logic [DW-1:0]     rd_d;

  always_comb begin
    if (bus_addr == MODE_OFS)      sel = SEL_MODE;
    else if (bus_addr == CMD_OFS)  sel = SEL_CMD;
    else if (bus_addr == STAT_OFS) sel = SEL_STAT;
    else                           sel = SEL_NONE;
  end

  can_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .wr_mode  (bus_wr && sel == SEL_MODE),
    .wdata    (bus_wdata[MODE_W-1:0]),
    .mode_q   (mode_q),
    .init_o   (init_mode),
    .listen_o (listen_mode),
    .loop_o   (loopback_mode),
    .filt_o   (single_filter),
    .sleep_o  (sleep_mode)
  );

  can_cmd_strobe u_cmd (
    .clk      (clk),
    .rst      (rst),
    .wr_cmd   (bus_wr && sel == SEL_CMD),
    .in_init  (mode_q[MB_INIT]),
    .wdata    (bus_wdata[CMD_W-1:0]),
    .strobe_q (cmd_strobe)
  );

  can_status_word u_stat (
    .clk       (clk),
    .rst       (rst),
    .rx_ready  (rx_ready),
    .tx_ready  (tx_ready),
    .tx_done   (tx_done),
    .rx_busy   (rx_busy),
    .tx_busy   (tx_busy),
    .err_warn  (err_warn),
    .bus_off   (bus_off),
    .ovr_event (ovr_event),
    .clr_ovr   (cmd_strobe[CB_CLR_OVR]),
    .status_q  (status_q)
  );

  always_comb begin
    rd_d = '0;
    case (sel)
      SEL_MODE: rd_d[MODE_W-1:0] = mode_q;
      SEL_STAT: rd_d[STAT_W-1:0] = status_q;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  // R6
  cmd_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr == CMD_OFS) |-> bus_rdata == '0);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr != MODE_OFS && bus_addr != CMD_OFS && bus_addr != STAT_OFS)
      |-> bus_rdata == '0);
endmodule

// File: tb/test_can_ctrl_regs.sv
`timescale 1ns/100ps
module test_can_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        init_mode, listen_mode, loopback_mode, single_filter, sleep_mode;
  logic [5:0]  cmd_strobe;
  logic        rx_ready = 0, tx_ready = 0, tx_done = 0, rx_busy = 0;
  logic        tx_busy = 0, err_warn = 0, bus_off = 0, ovr_event = 0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  can_ctrl_regs i_can_ctrl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .init_mode(init_mode), .listen_mode(listen_mode),
    .loopback_mode(loopback_mode), .single_filter(single_filter),
    .sleep_mode(sleep_mode), .cmd_strobe(cmd_strobe),
    .rx_ready(rx_ready), .tx_ready(tx_ready), .tx_done(tx_done),
    .rx_busy(rx_busy), .tx_busy(tx_busy), .err_warn(err_warn),
    .bus_off(bus_off), .ovr_event(ovr_event)
  );

  // behavioural reference, written from the requirements
  int          m_mode, m_cmd, m_eng, m_rd, m_addr_prev;
  bit          m_ovr;

  function automatic int rd_word(int a);
    if (a == 0) return m_mode;                       // R2
    if (a == 8) return m_eng | (m_ovr ? 2 : 0);      // R7
    return 0;                                        // R6, R10
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_mode = 1; m_cmd = 0; m_ovr = 0; m_eng = 'h3C; m_rd = 0;   // R1
      started = 1;
    end else begin
      int nm;
      m_rd = rd_word(bus_addr);
      nm = m_mode;
      if (bus_wr && bus_addr == 0) begin
        if (m_mode % 2 == 1) nm = bus_wdata[4:0];               // R3
        else nm = (m_mode & 'h18) | bus_wdata[2:0];
      end
      if (cmd_strobe[3] === 1'b1 && !ovr_event) m_ovr = 0;    // R8
      if (m_cmd & 8) begin if (!ovr_event) m_ovr = 0; end
      if (ovr_event) m_ovr = 1;
      m_eng = (bus_off << 7) | (err_warn << 6) | (tx_busy << 5) | (rx_busy << 4)
            | (tx_done << 3) | (tx_ready << 2) | rx_ready;
      m_cmd = (bus_wr && bus_addr == 4 && m_mode % 2 == 0) ? bus_wdata[5:0] : 0; // R4, R5
      m_mode = nm;
    end
    m_addr_prev = bus_addr;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      string rtag;
      rtag = (m_addr_prev == 0) ? "R2" : (m_addr_prev == 4) ? "R6" :
             (m_addr_prev == 8) ? "R7" : "R10";
      chk(rtag, bus_rdata, m_rd);
      chk("R11 init_mode", init_mode, m_mode & 1);
      chk("R9 loopback_mode", loopback_mode, (m_mode >> 2) & 1);
      chk("R9 listen_mode", listen_mode, ((m_mode >> 1) & 1) & ~((m_mode >> 2) & 1) & 1);
      chk("R3 single_filter", single_filter, (m_mode >> 3) & 1);
      chk("R3 sleep_mode", sleep_mode, (m_mode >> 4) & 1);
      chk("R4 cmd_strobe", cmd_strobe, m_cmd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a[7:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    bus_addr = a[7:0];
    @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    rd(8); rd(0);                      // R1, R7 reset contents
    wr(0, 'h19); rd(0);                // R3 unlocked in init
    wr(4, 'h3F); idle(2);              // R5 ignored in init
    wr(0, 'h18); rd(0);                // R11 leave init
    wr(0, 'h00); rd(0);                // R3 locked bits held
    wr(0, 'h06); rd(0);                // R9 loopback wins
    wr(0, 'h02); rd(0);                // R9 listen alone
    wr(4, 'h01); wr(4, 'h02); wr(4, 'h04);
    wr(4, 'h10); wr(4, 'h20);          // R4 each strobe
    @(negedge clk); bus_wr = 1; bus_addr = 4; bus_wdata = 'hFFFF_FFFF;
    @(negedge clk); bus_wdata = 'h15;
    @(negedge clk); bus_wr = 0;        // R4 back-to-back
    rd(4);                             // R6
    rx_ready = 1; tx_busy = 1; bus_off = 1; tx_ready = 0;
    rd(8); rd(8);                      // R7 pattern
    rx_ready = 0; err_warn = 1; tx_done = 1; rx_busy = 1; bus_off = 0;
    rd(8);
    @(negedge clk); ovr_event = 1;
    @(negedge clk); ovr_event = 0;
    rd(8); rd(8);                      // R8 set
    wr(4, 'h08); rd(8); rd(8);         // R8 clear
    @(negedge clk); ovr_event = 1; bus_wr = 1; bus_addr = 4; bus_wdata = 'h08;
    @(negedge clk); bus_wr = 0; bus_addr = 8;
    @(negedge clk); ovr_event = 0; idle(3); // R8 set wins over clear
    rd('h0C); rd('h40); rd('hFF);      // R10 unmapped
    wr(0, 'h01); rd(0);                // R3 re-enter init, locked bits kept
    wr(0, 'h00); rd(0);                // R3 now writable
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule